// File: doc/BRIEF.md
# Dual-Style Host Bus Register Slave

This block lets an external host processor read and write a bank of 32 byte-wide registers inside the chip. Four bus styles are supported. Static configuration pins choose Intel-style timing (separate active-low write and read strobes, with an active-high ready) or Motorola-style timing (an active-low data strobe, a read/write direction line and an active-low acknowledge). The same pins also choose whether the address arrives on its own 5-bit bus or is multiplexed with data on the 8-bit bus.

Every host pin passes through a two-stage synchronizer into the internal clock domain. A decoder then forms chip-select, read, write and address-strobe qualifiers for the selected style. It holds the multiplexed address, captures write data, emits a single write pulse to the register file and enables the read-data driver. A small handshake stage raises ready or acknowledge and holds it until chip select goes away. A port-enable input idles the whole port when it is low, for example when another host path owns the register file.

Top module: `hbus_slave`

## Requirements
- R1: `intel_sel` high selects Intel-style decoding of the shared strobe pins; low selects Motorola-style decoding.
- R2: While `port_en` is low, no register write is issued, `ad_oe` stays low and the handshake output stays inactive. The register contents seen later through normal reads are unchanged.
- R3: With `mux_sel` low, the register address is taken from `addr_in`, and `ale_as` has no effect.
- R4: With `mux_sel` high, the address is taken from `ad_in[4:0]` while the address strobe is active (ALE high in Intel style, AS_n low in Motorola style). It is held after the strobe ends.
- R5: Intel style: `cs_n` low with `rd_rw` (RD_n) low is a read, and `cs_n` low with `wr_ds_n` (WR_n) low is a write. `rdy_ack` is active high.
- R6: Motorola style: `cs_n` low with `wr_ds_n` (DS_n) low is an access. It is a read when `rd_rw` is 1 and a write when `rd_rw` is 0. `rdy_ack` is active low.
- R7: `ad_oe` is high exactly while the synchronized chip select and read qualifier are both active. `ad_out` then carries the register addressed.
- R8: Each write access commits exactly one one-cycle `rf_we` pulse. The pulse comes in the cycle after the synchronized write qualifier (with chip select) ends, and carries the last data seen on `ad_in` during the access.
- R9: The handshake goes active one internal clock after the synchronized access is recognized. It stays active while chip select remains active and is released the clock after chip select goes inactive.
- R10: After reset, `rf_we` and `ad_oe` are low and the handshake is inactive. Every pin passes through two synchronizer stages before it is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Parallel port enable (low: port ignores the bus) |
| intel_sel | input | 1 | Bus timing style: 1 Intel, 0 Motorola |
| mux_sel | input | 1 | 1 multiplexed address/data, 0 separate address bus |
| cs_n | input | 1 | Chip select, active low |
| wr_ds_n | input | 1 | WR_n (Intel) or DS_n (Motorola) |
| rd_rw | input | 1 | RD_n (Intel) or read/write direction, 1 = read (Motorola) |
| ale_as | input | 1 | ALE, active high (Intel) or AS_n, active low (Motorola) |
| addr_in | input | 5 | Dedicated address bus (non-multiplexed) |
| ad_in | input | 8 | Data bus, or shared address/data bus |
| ad_out | output | 8 | Read data toward the bus |
| ad_oe | output | 1 | Output enable for the read data |
| rdy_ack | output | 1 | Ready (Intel, high) or acknowledge (Motorola, low) |
| rf_addr | output | 5 | Register file address |
| rf_wdata | output | 8 | Register file write data |
| rf_we | output | 1 | Register file write strobe, one cycle |
| rf_rdata | input | 8 | Register file read data |

## Verification
The hardest situation to reach is a multiplexed access in which the shared bus carries an address and then, later in the same access, unrelated data. That data must land at the held address and not at whatever the bus shows when the write pulse fires. The stimulus puts an address with random upper bits on the shared bus under the address strobe and releases the strobe. It then drives the data, so a design that re-sampled the bus would write to the wrong location, and a later read-back would show the error. It also toggles the address strobe randomly in non-multiplexed mode to show that the strobe is ignored there.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    // Control pins in the order they are synchronized.
    typedef struct packed {
        logic cs_n;
        logic strb_n;   // WR_n or DS_n
        logic dir;      // RD_n or R/W (1 = read)
        logic astb;     // ALE (high) or AS_n (low)
    } ctl_pins_t;

    localparam int CTL_W = $bits(ctl_pins_t);

    // Decoded qualifiers, all gated by the port enable.
    typedef struct packed {
        logic cs;
        logic rd;
        logic wr;
        logic as;
    } qual_t;

    typedef enum logic [1:0] {
        STY_MOT_SEP = 2'b00,
        STY_MOT_MUX = 2'b01,
        STY_INT_SEP = 2'b10,
        STY_INT_MUX = 2'b11
    } bus_style_e;

    function automatic bus_style_e style_of(input logic intel, input logic mux);
        return bus_style_e'({intel, mux});
    endfunction

    function automatic logic style_is_mux(input bus_style_e s);
        return (s == STY_INT_MUX) || (s == STY_MOT_MUX);
    endfunction

    function automatic logic style_is_intel(input bus_style_e s);
        return (s == STY_INT_MUX) || (s == STY_INT_SEP);
    endfunction

    // Idle pin levels, used as synchronizer reset values.
    function automatic ctl_pins_t idle_pins(input logic intel);
        ctl_pins_t p;
        p.cs_n   = 1'b1;
        p.strb_n = 1'b1;
        p.dir    = 1'b1;
        p.astb   = ~intel;
        return p;
    endfunction

    function automatic qual_t decode_qual(input logic en, input bus_style_e s,
                                          input ctl_pins_t p);
        qual_t r;
        r.cs = en & ~p.cs_n;
        if (style_is_intel(s)) begin
            r.rd = ~p.dir;
            r.wr = ~p.strb_n;
            r.as = en & p.astb;
        end else begin
            r.rd = ~p.strb_n & p.dir;
            r.wr = ~p.strb_n & ~p.dir;
            r.as = en & ~p.astb;
        end
        return r;
    endfunction

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] rst_val,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                stg[k] <= rst_val;
            else if (k == 0)
                stg[k] <= d;
            else
                stg[k] <= stg[(k == 0) ? 0 : k - 1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hbus_decode.sv
module hbus_decode
    import hbus_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  bus_style_e        style,
    input  ctl_pins_t         pins,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] ad_s,
    output qual_t             q,
    output logic              acc,
    output logic [ADDR_W-1:0] rf_addr,
    output logic [DATA_W-1:0] wdata,
    output logic              we,
    output logic              oe
);
    logic              wacc, racc, wprev;
    logic [ADDR_W-1:0] alat;
    logic [DATA_W-1:0] dlat;

    always_comb begin
        q    = decode_qual(en, style, pins);
        wacc = q.cs & q.wr;
        racc = q.cs & q.rd;
        acc  = wacc | racc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wprev <= 1'b0;
            alat  <= '0;
            dlat  <= '0;
        end else begin
            wprev <= wacc;
            if (q.as) alat <= ad_s[ADDR_W-1:0];
            if (wacc) dlat <= ad_s;
        end
    end

    assign rf_addr = style_is_mux(style) ? alat : addr_s;
    assign wdata   = dlat;
    assign we      = wprev & ~wacc;
    assign oe      = racc;
endmodule

// File: rtl/hbus_handshake.sv
module hbus_handshake (
    input  logic clk,
    input  logic rst,
    input  logic intel,
    input  logic cs,
    input  logic acc,
    output logic rdy_act,
    output logic rdy_ack
);
    always_ff @(posedge clk) begin
        if (rst)
            rdy_act <= 1'b0;
        else
            rdy_act <= cs & (rdy_act | acc);
    end

    assign rdy_ack = intel ? rdy_act : ~rdy_act;
endmodule

// File: rtl/hbus_slave.sv
module hbus_slave
    import hbus_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              port_en,
    input  logic              intel_sel,
    input  logic              mux_sel,
    input  logic              cs_n,
    input  logic              wr_ds_n,
    input  logic              rd_rw,
    input  logic              ale_as,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              rdy_ack,
    output logic [ADDR_W-1:0] rf_addr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              rf_we,
    input  logic [DATA_W-1:0] rf_rdata
);
    localparam int SYNC_W = CTL_W + ADDR_W + DATA_W;

    bus_style_e        style;
    ctl_pins_t         ctl_raw, ctl_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] ad_s;
    logic [SYNC_W-1:0] sync_d, sync_q, sync_rst;
    qual_t             q_s;
    logic              acc, cs_act, rdy_act;

    assign style    = style_of(intel_sel, mux_sel);
    assign ctl_raw  = '{cs_n: cs_n, strb_n: wr_ds_n, dir: rd_rw, astb: ale_as};
    assign sync_d   = {ctl_raw, addr_in, ad_in};
    assign sync_rst = {idle_pins(intel_sel), {ADDR_W{1'b0}}, {DATA_W{1'b0}}};

    hbus_sync #(.W(SYNC_W), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .rst_val (sync_rst),
        .d       (sync_d),
        .q       (sync_q)
    );

    assign {ctl_s, addr_s, ad_s} = sync_q;

    hbus_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .clk     (clk),
        .rst     (rst),
        .en      (port_en),
        .style   (style),
        .pins    (ctl_s),
        .addr_s  (addr_s),
        .ad_s    (ad_s),
        .q       (q_s),
        .acc     (acc),
        .rf_addr (rf_addr),
        .wdata   (rf_wdata),
        .we      (rf_we),
        .oe      (ad_oe)
    );

    assign cs_act = q_s.cs;

    hbus_handshake u_hs (
        .clk     (clk),
        .rst     (rst),
        .intel   (intel_sel),
        .cs      (cs_act),
        .acc     (acc),
        .rdy_act (rdy_act),
        .rdy_ack (rdy_ack)
    );

    assign ad_out = rf_rdata;
endmodule

// File: rtl/hbus_slave_chk.sv
module hbus_slave_chk (
    input logic clk,
    input logic rst,
    input logic port_en,
    input logic cs_n,
    input logic cs_act,
    input logic acc,
    input logic rdy_act,
    input logic rf_we,
    input logic ad_oe
);
    AST_WE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        rf_we |=> !rf_we);                                        // R8

    AST_PORT_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
        !port_en |-> (!rf_we && !ad_oe));                         // R2

    AST_READY_RELEASE: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> !rdy_act);                                    // R9

    AST_READY_AFTER_ACCESS: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy_act) |-> $past(acc));                           // R9

    AST_DRIVE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
        ad_oe |-> (port_en && $past(!cs_n, 2)));                  // R7
endmodule

bind hbus_slave hbus_slave_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .port_en (port_en),
    .cs_n    (cs_n),
    .cs_act  (cs_act),
    .acc     (acc),
    .rdy_act (rdy_act),
    .rf_we   (rf_we),
    .ad_oe   (ad_oe)
);

// File: tb/hbus_slave_tb.sv
`timescale 1ns/1ps
module hbus_slave_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic port_en = 1'b1, intel_sel = 1'b1, mux_sel = 1'b0;
    logic cs_n = 1'b1, wr_ds_n = 1'b1, rd_rw = 1'b1, ale_as = 1'b0;
    logic [4:0] addr_in = '0;
    logic [7:0] ad_in = '0;
    logic [7:0] ad_out, rf_wdata, rf_rdata;
    logic [4:0] rf_addr;
    logic ad_oe, rdy_ack, rf_we;

    int compared = 0, mismatched = 0;
    string cur_tag = "R10";
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    hbus_slave u_dut (
        .clk(clk), .rst(rst), .port_en(port_en), .intel_sel(intel_sel), .mux_sel(mux_sel),
        .cs_n(cs_n), .wr_ds_n(wr_ds_n), .rd_rw(rd_rw), .ale_as(ale_as),
        .addr_in(addr_in), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .rdy_ack(rdy_ack), .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_we(rf_we),
        .rf_rdata(rf_rdata)
    );

    // Register file stand-in, written only by the block.
    logic [7:0] rf_mem  [32];
    logic [7:0] exp_mem [32];
    assign rf_rdata = rf_mem[rf_addr];
    always @(posedge clk) if (rf_we) rf_mem[rf_addr] <= rf_wdata;

    // Reference model. Pin snapshot: {cs_n, strobe_n, dir, astb, addr[4:0], ad[7:0]}
    logic [16:0] m_s1, m_s2, pins_now;
    logic        m_rdy, m_wprev;
    logic [4:0]  m_alat;
    logic [7:0]  m_dlat;
    assign pins_now = {cs_n, wr_ds_n, rd_rw, ale_as, addr_in, ad_in};

    logic m_cs, m_strb, m_dir, m_rd, m_wr, m_as, m_wacc, e_oe, e_we, e_rdy;
    logic [4:0] e_addr;
    assign m_cs   = port_en && !m_s2[16];
    assign m_strb = !m_s2[15];
    assign m_dir  = m_s2[14];
    assign m_rd   = intel_sel ? !m_dir : (m_strb && m_dir);     // R5 / R6
    assign m_wr   = intel_sel ? m_strb : (m_strb && !m_dir);
    assign m_as   = port_en && (intel_sel ? m_s2[13] : !m_s2[13]);
    assign m_wacc = m_cs && m_wr;
    assign e_oe   = m_cs && m_rd;
    assign e_we   = m_wprev && !m_wacc;
    assign e_addr = mux_sel ? m_alat : m_s2[12:8];
    assign e_rdy  = intel_sel ? m_rdy : !m_rdy;

    always @(posedge clk) begin
        logic n_rdy, n_wprev;
        if (rst) begin
            m_s1 = {3'b111, !intel_sel, 13'd0};
            m_s2 = m_s1;
            m_rdy = 0; m_wprev = 0; m_alat = 0; m_dlat = 0;
        end else begin
            if (e_we) exp_mem[e_addr] = m_dlat;
            n_rdy   = m_cs && (m_rdy || m_wacc || (m_cs && m_rd));
            n_wprev = m_wacc;
            if (m_as)   m_alat = m_s2[4:0];
            if (m_wacc) m_dlat = m_s2[7:0];
            m_rdy = n_rdy; m_wprev = n_wprev;
            m_s2 = m_s1; m_s1 = pins_now;
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, got, exp, $time);
        end
    endtask

    // Compare on every clock, away from the rising edge.
    always @(negedge clk) begin
        if (!done) begin
            string t;
            t = rst ? "R10" : cur_tag;
            chk(t, "rdy_ack (R9)", {31'd0, rdy_ack}, {31'd0, e_rdy});
            chk(t, "ad_oe (R7)", {31'd0, ad_oe}, {31'd0, e_oe});
            chk(t, "rf_we (R8)", {31'd0, rf_we}, {31'd0, e_we});
            if (e_we) begin
                chk(t, "rf_addr", {27'd0, rf_addr}, {27'd0, e_addr});
                chk(t, "rf_wdata (R8)", {24'd0, rf_wdata}, {24'd0, m_dlat});
            end
            if (e_oe)
                chk(t, "ad_out (R7)", {24'd0, ad_out}, {24'd0, exp_mem[e_addr]});
        end
    end

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic idle_bus();
        cs_n = 1; wr_ds_n = 1; rd_rw = 1; ale_as = !intel_sel;
    endtask

    task automatic do_reset(input logic en, input logic intel, input logic mux, input string tag);
        rst = 1; cur_tag = "R10";
        port_en = en; intel_sel = intel; mux_sel = mux;
        idle_bus(); addr_in = 0; ad_in = 0;
        tick(3);
        rst = 0;
        tick(3);
        cur_tag = tag;
    endtask

    task automatic bus_access(input bit is_wr, input logic [4:0] a, input logic [7:0] d);
        if (mux_sel) begin
            // R4: address under the strobe, then unrelated values on the shared bus
            ad_in = {3'($urandom), a};
            ale_as = intel_sel ? 1'b1 : 1'b0;
            tick(3);
            ale_as = !intel_sel;
            tick(1);
            ad_in = is_wr ? d : 8'($urandom);
        end else begin
            // R3: address bus used, address strobe toggles freely
            addr_in = a;
            ale_as = 1'($urandom);
            ad_in = is_wr ? d : 8'($urandom);
        end
        cs_n = 0;
        tick(1);
        if (intel_sel) begin
            if (is_wr) wr_ds_n = 0; else rd_rw = 0;
        end else begin
            rd_rw = !is_wr;
            tick(1);
            wr_ds_n = 0;
        end
        if (!mux_sel) ale_as = 1'($urandom);
        tick(5);
        wr_ds_n = 1; rd_rw = 1;
        tick(3);
        cs_n = 1;
        tick(4);
        idle_bus();
        addr_in = 5'($urandom);
        tick(1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL R10 watchdog: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            done = 1;
            $finish;
        end
    end

    initial begin
        logic [4:0] adr [6];
        process::self().srandom(7);
        for (int i = 0; i < 32; i++) begin rf_mem[i] = 8'h00; exp_mem[i] = 8'h00; end

        // R1: each of the four styles in turn
        for (int st = 0; st < 4; st++) begin
            string tg;
            tg = st[0] ? "R4" : (st[1] ? "R5" : "R6");
            do_reset(1'b1, st[1], st[0], tg);
            for (int k = 0; k < 6; k++) begin
                adr[k] = 5'($urandom);
                bus_access(1'b1, adr[k], 8'($urandom));
            end
            for (int k = 0; k < 6; k++) bus_access(1'b0, adr[k], 8'h00);
            // boundary addresses
            bus_access(1'b1, 5'd0, 8'hA5);
            bus_access(1'b1, 5'd31, 8'h5A);
            bus_access(1'b0, 5'd31, 8'h00);
            bus_access(1'b0, 5'd0, 8'h00);
        end

        // R2: port disabled, writes must leave the registers untouched
        do_reset(1'b0, 1'b1, 1'b0, "R2");
        for (int k = 0; k < 4; k++) bus_access(1'b1, adr[k], ~exp_mem[adr[k]]);
        do_reset(1'b0, 1'b0, 1'b1, "R2");
        bus_access(1'b1, 5'd31, 8'h00);
        do_reset(1'b1, 1'b1, 1'b0, "R2");
        for (int k = 0; k < 4; k++) bus_access(1'b0, adr[k], 8'h00);
        bus_access(1'b0, 5'd31, 8'h00);

        tick(4);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule